// File: doc/BRIEF.md
# Biphasic Stimulus Sequencer

This block produces the digital amplitude code for a 9-bit stimulation current DAC. A host loads the stimulus pattern over a slow three-wire serial port (data, shift clock, store strobe). Five 9-bit time instants and four 9-bit amplitude codes accumulate in a shadow register. A store request moves them into the active register bank, but only at the end of the running stimulus period, so a period is never played with a mix of old and new settings.

In pattern mode, a free-running prescaler makes a tick. A 9-bit counter advances on each tick and is compared against the time instant that a read multiplexer picks for the current phase. When the two match, the waveform moves to the next phase. The phases play amplitudes 0, 1, 2 and 3 in turn, then a rest phase plays amplitude 0 again. At the last instant the counter returns to zero and the period repeats. A rest indicator marks the final phase for the charge balancer. In arbitrary mode, the block samples an external amplitude word once every fixed number of ticks and forwards it unchanged to the DAC.

Top module: `stim_seq`

## Requirements
- R1: The serial frame is 81 bits, sent most significant bit first, each bit taken on a rising edge of the shift clock. In sending order, the frame holds time instants 0 to 4 and then amplitudes 0 to 3, each field 9 bits wide.
- R2: Shifting frame bits without a store request leaves the output code and the rest indicator unchanged.
- R3: A rising edge on the store strobe commits the shadow frame only at the next period boundary. The rest of the running period keeps the old settings, and the next period uses the new ones.
- R4: With instants T0<T1<T2<T3<T4 and counter value k ticks since the period start, the output is amplitude 0 for k<=T0, amplitude 1 for T0<k<=T1, amplitude 2 for T1<k<=T2, amplitude 3 for T2<k<=T3, and amplitude 0 for T3<k<=T4. A tick lasts TICK_DIV clock cycles.
- R5: In pattern mode the rest indicator is high exactly while T3<k<=T4. In arbitrary mode it is always low.
- R6: After k=T4 the counter returns to 0, so the pattern repeats every T4+1 ticks.
- R7: In arbitrary mode the output takes the external amplitude word sampled once every ARB_TICKS ticks. Between two samples the output holds, whatever the external word does.
- R8: During and right after reset, the output code is 0 and the rest indicator is low. The active amplitudes reset to 0, and the active instants reset to DEF_STEP*(i+1)-1.
- R9: The output code passes through unchanged: bit 8 is the polarity and bits 7:0 are the magnitude, with no remapping of any of the 512 values.
- R10: The mode select acts combinationally. Switching to arbitrary mode shows the most recently sampled external word. Switching back shows the running pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serData | input | 1 | Serial frame data |
| serClk | input | 1 | Serial shift clock, oversampled by clk |
| storeStb | input | 1 | Store request, rising edge sensitive |
| modeArb | input | 1 | 0 = pattern mode, 1 = arbitrary mode |
| extAmp | input | AMP_W | External amplitude word for arbitrary mode |
| dacCode | output | AMP_W | Code to the current DAC |
| restFlag | output | 1 | High during the rest phase of pattern mode |

## Verification
The properties assume that the loaded time instants strictly increase, and that each serial clock level, data bit and store level is held longer than the synchronizer depth plus one clock. They also assume that no store request arrives within a few cycles of a period boundary, and that the mode select is synchronous to clk. The stimulus draws instants with increments of at least two ticks. It holds every serial level for four clocks and raises the store strobe early in a period, far from its end. It changes the mode and the external word only between clock edges.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;

  localparam int N_TIMES = 5;
  localparam int N_AMPS  = 4;

  typedef enum logic [2:0] {
    PH_A0   = 3'd0,
    PH_A1   = 3'd1,
    PH_A2   = 3'd2,
    PH_A3   = 3'd3,
    PH_REST = 3'd4
  } phase_t;

  typedef struct packed {
    logic   shift;
    logic   shiftBit;
    logic   commit;
    logic   arbLatch;
    phase_t phase;
  } seq_strobes_t;

endpackage

// File: rtl/stim_seq_sync.sv
module stim_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  generate
    if (STAGES > 1) begin : g_multi
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[STAGES-2:0], d};
      end
      assign q = pipe[STAGES-1];
    end else begin : g_single
      logic pipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= 1'b0;
        else       pipe <= d;
      end
      assign q = pipe;
    end
  endgenerate
endmodule

// File: rtl/stim_seq_ctrl.sv
module stim_seq_ctrl
  import stim_seq_pkg::*;
#(
  parameter int TIME_W      = 9,
  parameter int TICK_DIV    = 4,
  parameter int ARB_TICKS   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              storeStb,
  input  logic [TIME_W-1:0] selTime,
  output seq_strobes_t      strb
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int ARB_W = (ARB_TICKS > 1) ? $clog2(ARB_TICKS) : 1;
  localparam int N_SYNC = 3;

  // synchronize the slow serial port into the system clock
  logic [N_SYNC-1:0] rawIn;
  logic [N_SYNC-1:0] syncIn;
  assign rawIn = {serClk, serData, storeStb};

  generate
    for (genvar s = 0; s < N_SYNC; s++) begin : g_sync
      stim_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rstN(rstN),
        .d   (rawIn[s]),
        .q   (syncIn[s])
      );
    end
  endgenerate

  logic sClk, sDat, sStb;
  assign sClk = syncIn[2];
  assign sDat = syncIn[1];
  assign sStb = syncIn[0];

  logic prevClk, prevStb;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      prevStb <= 1'b0;
    end else begin
      prevClk <= sClk;
      prevStb <= sStb;
    end
  end

  logic shiftEdge, storeEdge;
  assign shiftEdge = sClk & ~prevClk;
  assign storeEdge = sStb & ~prevStb;

  // tick prescaler
  logic tick;
  generate
    if (TICK_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                              preCnt <= '0;
        else if (preCnt == PRE_W'(TICK_DIV-1)) preCnt <= '0;
        else                                    preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PRE_W'(TICK_DIV-1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  // phase engine: one counter, one comparator against the muxed instant
  logic [TIME_W-1:0] cnt;
  phase_t            phaseQ;
  logic              hit, wrap, pending, commitNow;

  assign hit       = tick && (cnt == selTime);
  assign wrap      = hit && (phaseQ == PH_REST);
  assign commitNow = wrap && pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      phaseQ <= PH_A0;
    end else if (tick) begin
      if (wrap) begin
        cnt    <= '0;
        phaseQ <= PH_A0;
      end else begin
        cnt <= cnt + 1'b1;
        if (hit) phaseQ <= phase_t'(phaseQ + 3'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= storeEdge | (pending & ~commitNow);
  end

  // arbitrary-mode sampling interval
  logic [ARB_W-1:0] arbCnt;
  logic             arbNow;
  assign arbNow = tick && (arbCnt == ARB_W'(ARB_TICKS-1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       arbCnt <= '0;
    else if (arbNow) arbCnt <= '0;
    else if (tick)   arbCnt <= arbCnt + 1'b1;
  end

  always_comb begin
    strb.shift    = shiftEdge;
    strb.shiftBit = sDat;
    strb.commit   = commitNow;
    strb.arbLatch = arbNow;
    strb.phase    = phaseQ;
  end
endmodule

// File: rtl/stim_seq_dp.sv
module stim_seq_dp
  import stim_seq_pkg::*;
#(
  parameter int TIME_W   = 9,
  parameter int AMP_W    = 9,
  parameter int DEF_STEP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobes_t      strb,
  input  logic              modeArb,
  input  logic [AMP_W-1:0]  extAmp,
  output logic [TIME_W-1:0] selTime,
  output logic [AMP_W-1:0]  dacCode
);
  localparam int AMP_BITS = N_AMPS * AMP_W;
  localparam int FRAME_W  = N_TIMES * TIME_W + AMP_BITS;

  // shadow frame, MSB first
  logic [FRAME_W-1:0] shadow;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shadow <= '0;
    else if (strb.shift) shadow <= {shadow[FRAME_W-2:0], strb.shiftBit};
  end

  // active register bank
  logic [TIME_W-1:0] timeReg [N_TIMES];
  logic [AMP_W-1:0]  ampReg  [N_AMPS];

  generate
    for (genvar i = 0; i < N_TIMES; i++) begin : g_time
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            timeReg[i] <= TIME_W'(DEF_STEP * (i + 1) - 1);
        else if (strb.commit) timeReg[i] <= shadow[FRAME_W-1-i*TIME_W -: TIME_W];
      end
    end
    for (genvar j = 0; j < N_AMPS; j++) begin : g_amp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            ampReg[j] <= '0;
        else if (strb.commit) ampReg[j] <= shadow[AMP_BITS-1-j*AMP_W -: AMP_W];
      end
    end
  endgenerate

  // read multiplexers
  logic [AMP_W-1:0] ampSel;
  always_comb begin
    case (strb.phase)
      PH_A0:   begin selTime = timeReg[0]; ampSel = ampReg[0]; end
      PH_A1:   begin selTime = timeReg[1]; ampSel = ampReg[1]; end
      PH_A2:   begin selTime = timeReg[2]; ampSel = ampReg[2]; end
      PH_A3:   begin selTime = timeReg[3]; ampSel = ampReg[3]; end
      default: begin selTime = timeReg[4]; ampSel = ampReg[0]; end
    endcase
  end

  // arbitrary-mode sample register
  logic [AMP_W-1:0] arbReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              arbReg <= '0;
    else if (strb.arbLatch) arbReg <= extAmp;
  end

  assign dacCode = modeArb ? arbReg : ampSel;
endmodule

// File: rtl/stim_seq.sv
module stim_seq
  import stim_seq_pkg::*;
#(
  parameter int TIME_W      = 9,
  parameter int AMP_W       = 9,
  parameter int TICK_DIV    = 4,
  parameter int ARB_TICKS   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_STEP    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serData,
  input  logic             serClk,
  input  logic             storeStb,
  input  logic             modeArb,
  input  logic [AMP_W-1:0] extAmp,
  output logic [AMP_W-1:0] dacCode,
  output logic             restFlag
);
  seq_strobes_t      ctlStb;
  logic [TIME_W-1:0] selTime;

  stim_seq_ctrl #(
    .TIME_W     (TIME_W),
    .TICK_DIV   (TICK_DIV),
    .ARB_TICKS  (ARB_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .serData (serData),
    .storeStb(storeStb),
    .selTime (selTime),
    .strb    (ctlStb)
  );

  stim_seq_dp #(
    .TIME_W  (TIME_W),
    .AMP_W   (AMP_W),
    .DEF_STEP(DEF_STEP)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (ctlStb),
    .modeArb(modeArb),
    .extAmp (extAmp),
    .selTime(selTime),
    .dacCode(dacCode)
  );

  assign restFlag = (ctlStb.phase == PH_REST) && !modeArb;
endmodule

// File: rtl/stim_seq_chk.sv
module stim_seq_chk
  import stim_seq_pkg::*;
#(
  parameter int AMP_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeArb,
  input logic [AMP_W-1:0] extAmp,
  input logic [AMP_W-1:0] dacCode,
  input logic             restFlag,
  input seq_strobes_t     strb
);
  // R7
  arb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeArb && !strb.arbLatch) ##1 modeArb |-> $stable(dacCode));

  // R7
  arb_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeArb && strb.arbLatch) ##1 modeArb |-> (dacCode == $past(extAmp)));

  // R3
  commit_at_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (restFlag || modeArb));

  // R4
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeArb && !strb.commit) ##1 (!modeArb && $stable(strb.phase)) |-> $stable(dacCode));

  // R6
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(strb.phase) |->
      ((strb.phase == phase_t'($past(strb.phase) + 3'd1)) ||
       (strb.phase == PH_A0 && $past(strb.phase) == PH_REST)));
endmodule

bind stim_seq stim_seq_chk #(.AMP_W(AMP_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .modeArb (modeArb),
  .extAmp  (extAmp),
  .dacCode (dacCode),
  .restFlag(restFlag),
  .strb    (ctlStb)
);

// File: tb/stim_seq_tb_top.sv
module stim_seq_tb_top;
  localparam int TD = 3;
  localparam int AT = 4;
  localparam int DS = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serData = 1'b0, serClk = 1'b0, storeStb = 1'b0, modeArb = 1'b0;
  logic [8:0] extAmp = 9'h0AB;
  logic [8:0] dacCode;
  logic       restFlag;

  int  errs = 0;
  int  checks = 0;
  bit  aligned = 0;
  bit  frameDone = 0;
  int  seedDummy;

  logic [8:0] expT [5];
  logic [8:0] expA [4];
  logic [8:0] newT [5];
  logic [8:0] newA [4];

  always #4 clk = ~clk;

  stim_seq #(.TICK_DIV(TD), .ARB_TICKS(AT), .DEF_STEP(DS)) dut_i (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .storeStb(storeStb), .modeArb(modeArb), .extAmp(extAmp),
    .dacCode(dacCode), .restFlag(restFlag)
  );

  function automatic logic [8:0] expAmp(input int k);
    if (k <= int'(expT[0])) return expA[0];
    if (k <= int'(expT[1])) return expA[1];
    if (k <= int'(expT[2])) return expA[2];
    if (k <= int'(expT[3])) return expA[3];
    return expA[0];
  endfunction

  function automatic logic expRest(input int k);
    return k > int'(expT[3]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // R1: 81-bit frame, MSB first, t0..t4 then A0..A3
  task automatic sendFrame();
    logic [80:0] frame;
    frame = {newT[0], newT[1], newT[2], newT[3], newT[4],
             newA[0], newA[1], newA[2], newA[3]};
    for (int b = 80; b >= 0; b--) begin
      serData = frame[b];
      repeat (4) @(negedge clk);
      serClk = 1'b1;
      repeat (4) @(negedge clk);
      serClk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  // checks one full period against expT/expA (R1, R2, R4, R5, R6, R9)
  task automatic checkPeriod(input bit doStore, input string tag);
    int  len;
    bit  pr;
    int  guard;
    if (!aligned) begin
      pr = restFlag;
      guard = 0;
      forever begin
        @(negedge clk);
        guard++;
        if (pr && !restFlag) break;
        pr = restFlag;
        if (guard > 4000) begin
          chk(0, "R6 boundary never seen", 0, 1);
          return;
        end
      end
    end
    len = (int'(expT[4]) + 1) * TD;
    for (int j = 0; j < len; j++) begin
      if (j > 0) @(negedge clk);
      if (doStore && j == 3) storeStb = 1'b1;
      if (doStore && j == 9) storeStb = 1'b0;
      chk(dacCode == expAmp(j / TD), {tag, " R4 amplitude"}, int'(dacCode), int'(expAmp(j / TD)));
      chk(restFlag == expRest(j / TD), {tag, " R5 rest"}, int'(restFlag), int'(expRest(j / TD)));
    end
    @(negedge clk);
    chk(restFlag == 1'b0, {tag, " R6 wrap"}, int'(restFlag), 0);
    aligned = 1;
  endtask

  task automatic randomCfg();
    newT[0] = 9'($urandom_range(6, 1));
    for (int i = 1; i < 5; i++) newT[i] = newT[i-1] + 9'($urandom_range(8, 2));
    for (int i = 0; i < 4; i++) newA[i] = 9'($urandom_range(511, 0));
  endtask

  task automatic loadAndCheck();
    frameDone = 0;
    fork
      begin
        sendFrame();
        frameDone = 1;
      end
      begin
        while (!frameDone) checkPeriod(1'b0, "R2 shift-only");
      end
    join
    checkPeriod(1'b1, "R3 old-until-boundary");
    expT = newT;
    expA = newA;
    checkPeriod(1'b0, "R1 R9 new frame");
    checkPeriod(1'b0, "R6 repeat");
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [8:0] cur, nxt;
    int         n;
    int         waitCnt;
    seedDummy = int'($urandom(32'd20240611));
    for (int i = 0; i < 5; i++) expT[i] = 9'(DS * (i + 1) - 1);
    for (int i = 0; i < 4; i++) expA[i] = 9'h000;

    // R8 reset state
    repeat (3) @(negedge clk);
    chk(dacCode == 9'h000, "R8 code in reset", int'(dacCode), 0);
    chk(restFlag == 1'b0, "R8 rest in reset", int'(restFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(dacCode == 9'h000, "R8 code after reset", int'(dacCode), 0);
    chk(restFlag == 1'b0, "R8 rest after reset", int'(restFlag), 0);
    checkPeriod(1'b0, "R8 default timing");

    // directed: shortest phases, extreme codes (R9)
    newT[0] = 9'd0; newT[1] = 9'd1; newT[2] = 9'd2; newT[3] = 9'd3; newT[4] = 9'd4;
    newA[0] = 9'h1FF; newA[1] = 9'h100; newA[2] = 9'h0FF; newA[3] = 9'h000;
    loadAndCheck();
    // directed: longest period
    newT[0] = 9'd100; newT[1] = 9'd200; newT[2] = 9'd300; newT[3] = 9'd400; newT[4] = 9'd511;
    newA[0] = 9'h001; newA[1] = 9'h0C8; newA[2] = 9'h1C8; newA[3] = 9'h155;
    loadAndCheck();
    for (int c = 0; c < 4; c++) begin
      randomCfg();
      loadAndCheck();
    end

    // R10 switch to arbitrary mode, R5 rest low there
    modeArb = 1'b1;
    aligned = 0;
    @(negedge clk);
    chk(restFlag == 1'b0, "R5 rest low in arbitrary mode", int'(restFlag), 0);
    chk(dacCode == 9'h0AB, "R10 last sampled word", int'(dacCode), 'h0AB);

    // R7 sampling interval
    n = AT * TD;
    cur = 9'h0AB;
    do nxt = 9'($urandom_range(511, 0)); while (nxt == cur);
    extAmp = nxt;
    waitCnt = 0;
    while (dacCode != nxt && waitCnt <= n + 2) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(dacCode == nxt, "R7 first sample", int'(dacCode), int'(nxt));
    cur = nxt;
    for (int s = 0; s < 8; s++) begin
      do nxt = 9'($urandom_range(511, 0)); while (nxt == cur);
      if (s == 0) nxt = 9'h100;
      if (s == 1) nxt = 9'h1FF;
      extAmp = nxt;
      for (int i = 1; i < n; i++) begin
        @(negedge clk);
        if (i == n / 2) extAmp = ~nxt;
        if (i == n / 2 + 1) extAmp = nxt;
        chk(dacCode == cur, "R7 hold between samples", int'(dacCode), int'(cur));
        chk(restFlag == 1'b0, "R5 rest low in arbitrary mode", int'(restFlag), 0);
      end
      @(negedge clk);
      chk(dacCode == nxt, "R7 new sample", int'(dacCode), int'(nxt));
      cur = nxt;
    end

    // R10 back to pattern mode
    modeArb = 1'b0;
    checkPeriod(1'b0, "R10 pattern resumes");

    summary();
    $finish;
  end
endmodule